// File: doc/BRIEF.md
# Pass-Through and Control-Conflict Decoder

This block watches the active-low strobe and bypass controls of two 9-bit data ports and decides, once per system clock, which of four modes the port pair is in. The modes are normal operation (the FIFO and the single-word mailbox run as usual), an immediate pass-through from port A to port B, the same pass-through from B to A, and an exception mode for control combinations that cannot be served.

During a pass-through, the initiating port's input word goes straight to the other port's output, and a block signal stops the FIFO and mailbox logic from acting. A pass-through counts only when the strobe follows the bypass pin low within a parameter window of clock cycles. A later strobe leaves the bypass as a mailbox access and the strobe as a normal strobe. In exception mode both ports stop driving until the controls return to a legal combination. All four control pins pass through a two-flop synchronizer before they are decoded, so the mode register changes only on clock edges.

Top module: `bypass_arbiter`

## Requirements
- R1: While reset is asserted, mode is 0, a_oe, b_oe, fifo_block and exc are 0, and both data outputs are all zeros.
- R2: With a_stb_n and a_byp_n low and both B controls high, the block enters mode 1 (A to B). b_oe is 1, a_oe is 0, b_dout equals a_din and a_dout is zero.
- R3: With b_stb_n and b_byp_n low and both A controls high, the block enters mode 2 (B to A). a_oe is 1, b_oe is 0, a_dout equals b_din and b_dout is zero.
- R4: fifo_block is 1 in modes 1, 2 and 3, and 0 in mode 0.
- R5: A pass-through is accepted when a port's strobe goes low while its bypass has been low and its strobe high for fewer than WIN synchronized cycles. After WIN or more such cycles the port stays in mode 0 even once its strobe goes low, until its bypass returns high.
- R6: Each of the following puts the block in mode 3, with exc 1 and both output enables 0. The listed pins are low and all other pins are high: a_stb_n with b_byp_n; a_byp_n with b_byp_n; all four pins; both A pins with exactly one B pin; both B pins with exactly one A pin.
- R7: Exception mode lasts only while the conflicting combination is present. Legal controls return the block to the mode they select.
- R8: A change on the control pins reaches mode on the third rising clock edge after it, and not before.
- R9: While a pass-through is selected, the receiving output follows the sender's input with no clock edge in between.
- R10: A single low control pin, or a bypass low on one port together with a strobe low on the other port (a combination not listed in R6), leaves the block in mode 0 with fifo_block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_stb_n | input | 1 | Port A strobe, active low |
| a_byp_n | input | 1 | Port A bypass select, active low |
| b_stb_n | input | 1 | Port B strobe, active low |
| b_byp_n | input | 1 | Port B bypass select, active low |
| a_din | input | W | Word presented at port A |
| b_din | input | W | Word presented at port B |
| a_dout | output | W | Word driven out of port A |
| b_dout | output | W | Word driven out of port B |
| a_oe | output | 1 | Port A output enable |
| b_oe | output | 1 | Port B output enable |
| mode | output | 2 | 0 normal, 1 A to B, 2 B to A, 3 exception |
| fifo_block | output | 1 | Suppresses FIFO and mailbox actions |
| exc | output | 1 | Exception status |

## Verification
The embedded assertions check on every cycle that the two output enables are never on together and that neither is on during an exception. They also check that each pass-through mode was preceded by the matching pin pattern and that exception and blocking only follow cycles with at least two pins low. Only the directed scenarios can show the exact three-edge latency, the acceptance window on either side of its limit, each individual conflict pattern, and the same-cycle data path.

// File: rtl/bypass_arbiter.sv
module bypass_arbiter #(
  parameter int W   = 9,
  parameter int WIN = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_stb_n,
  input  logic         a_byp_n,
  input  logic         b_stb_n,
  input  logic         b_byp_n,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] b_din,
  output logic [W-1:0] a_dout,
  output logic [W-1:0] b_dout,
  output logic         a_oe,
  output logic         b_oe,
  output logic [1:0]   mode,
  output logic         fifo_block,
  output logic         exc
);
  localparam int CW = (WIN < 2) ? 1 : $clog2(WIN + 1);
  localparam logic [1:0] M_NORM = 2'd0, M_AB = 2'd1, M_BA = 2'd2, M_EXC = 2'd3;

  logic [3:0]    sy1, sy2, lo;
  logic [1:0]    late;
  logic [CW-1:0] cnt [2];
  logic          sa, ya, sb, yb, conflict, go_ab, go_ba;
  logic [1:0]    nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= 4'hF;
      sy2 <= 4'hF;
    end else begin
      sy1 <= {b_byp_n, b_stb_n, a_byp_n, a_stb_n};
      sy2 <= sy1;
    end

  assign lo = ~sy2;
  assign sa = lo[0];
  assign ya = lo[1];
  assign sb = lo[2];
  assign yb = lo[3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      late   <= '0;
      cnt[0] <= '0;
      cnt[1] <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (!lo[2*p+1]) begin
          cnt[p]  <= '0;
          late[p] <= 1'b0;
        end else if (!lo[2*p] && !late[p]) begin
          if (cnt[p] == CW'(WIN - 1)) late[p] <= 1'b1;
          else cnt[p] <= cnt[p] + 1'b1;
        end
      end
    end

  assign conflict = (sa & yb & ~ya & ~sb) | (ya & yb & ~sa & ~sb) | (&lo)
                  | (sa & ya & (sb ^ yb)) | (sb & yb & (sa ^ ya));
  assign go_ab = sa & ya & ~sb & ~yb & ~late[0];
  assign go_ba = sb & yb & ~sa & ~ya & ~late[1];
  assign nxt   = conflict ? M_EXC : go_ab ? M_AB : go_ba ? M_BA : M_NORM;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode <= M_NORM;
    else        mode <= nxt;

  assign b_oe       = (mode == M_AB);
  assign a_oe       = (mode == M_BA);
  assign exc        = (mode == M_EXC);
  assign fifo_block = (mode != M_NORM);
  assign b_dout     = b_oe ? a_din : '0;
  assign a_dout     = a_oe ? b_din : '0;

  AST_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe && b_oe)); // R2
  AST_EXC_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> (!a_oe && !b_oe)); // R6
  AST_AB_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_AB) |-> $past(lo == 4'b0011)); // R2
  AST_BA_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_BA) |-> $past(lo == 4'b1100)); // R3
  AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> ($countones($past(lo)) >= 2)); // R7
  AST_BLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_block |-> ($countones($past(lo)) >= 2)); // R4
  AST_LATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    late[0] |-> $past(ya)); // R5
endmodule

// File: tb/bypass_arbiter_test.sv
module bypass_arbiter_test;
  localparam int W = 9;
  localparam int WIN = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_stb_n = 1, a_byp_n = 1, b_stb_n = 1, b_byp_n = 1;
  logic [W-1:0] a_din = '0, b_din = '0;
  logic [W-1:0] a_dout, b_dout;
  logic a_oe, b_oe, fifo_block, exc;
  logic [1:0] mode;
  int checks = 0, errors = 0;
  bit done = 0;

  bypass_arbiter #(.W(W), .WIN(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .a_stb_n(a_stb_n), .a_byp_n(a_byp_n),
    .b_stb_n(b_stb_n), .b_byp_n(b_byp_n), .a_din(a_din), .b_din(b_din),
    .a_dout(a_dout), .b_dout(b_dout), .a_oe(a_oe), .b_oe(b_oe),
    .mode(mode), .fifo_block(fifo_block), .exc(exc));

  always #4 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pins(logic [3:0] v);
    @(negedge clk);
    {a_stb_n, a_byp_n, b_stb_n, b_byp_n} = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    check("R1 mode", mode, 0);
    check("R1 oe", {a_oe, b_oe}, 0);
    check("R1 block/exc", {fifo_block, exc}, 0);
    check("R1 dout", {a_dout, b_dout}, 0);
  endtask

  task automatic t_single();
    logic [3:0] pat [6] = '{4'b0111, 4'b1011, 4'b1101, 4'b1110, 4'b1001, 4'b0110};
    for (int i = 0; i < 6; i++) begin
      pins(pat[i]);
      if (i == 5) pins(4'b1110);
      settle();
      if (i == 5) begin
        check("R10 mode b-bypass", mode, 0);
        check("R10 block b-bypass", fifo_block, 0);
      end else begin
        check("R10 mode", mode, 0);
        check("R10 block", fifo_block, 0);
      end
      pins(4'hF);
      settle();
    end
  endtask

  task automatic t_ab();
    a_din = 9'h1A5;
    b_din = 9'h033;
    pins(4'b0011);
    settle();
    check("R2 mode", mode, 1);
    check("R2 oe", {a_oe, b_oe}, 2'b01);
    check("R2 b_dout", b_dout, 9'h1A5);
    check("R2 a_dout", a_dout, 0);
    check("R4 block AB", fifo_block, 1);
    a_din = 9'h05A;
    #1;
    check("R9 b_dout follows", b_dout, 9'h05A);
    pins(4'hF);
    settle();
    check("R4 block normal", fifo_block, 0);
  endtask

  task automatic t_ba();
    b_din = 9'h0C3;
    pins(4'b1100);
    settle();
    check("R3 mode", mode, 2);
    check("R3 oe", {a_oe, b_oe}, 2'b10);
    check("R3 a_dout", a_dout, 9'h0C3);
    check("R3 b_dout", b_dout, 0);
    check("R4 block BA", fifo_block, 1);
    b_din = 9'h101;
    #1;
    check("R9 a_dout follows", a_dout, 9'h101);
    pins(4'hF);
    settle();
  endtask

  task automatic t_latency();
    pins(4'b0011);
    @(posedge clk);
    @(posedge clk);
    #2;
    check("R8 not yet", mode, 0);
    @(posedge clk);
    #2;
    check("R8 third edge", mode, 1);
    pins(4'hF);
    settle();
  endtask

  task automatic t_window();
    pins(4'b1011);
    pins(4'b0011);
    settle();
    check("R5 early strobe", mode, 1);
    pins(4'hF);
    settle();
    pins(4'b1011);
    repeat (WIN + 6) @(negedge clk);
    pins(4'b0011);
    settle();
    check("R5 late strobe mode", mode, 0);
    check("R5 late strobe block", fifo_block, 0);
    pins(4'hF);
    settle();
    pins(4'b0011);
    settle();
    check("R5 rearmed", mode, 1);
    pins(4'hF);
    settle();
  endtask

  task automatic t_exc();
    logic [3:0] pat [7] = '{4'b0110, 4'b1010, 4'b0000, 4'b0001,
                            4'b0010, 4'b0100, 4'b1000};
    for (int i = 0; i < 7; i++) begin
      pins(pat[i]);
      settle();
      check("R6 mode", mode, 3);
      check("R6 exc", exc, 1);
      check("R6 oe", {a_oe, b_oe}, 0);
      check("R4 block exc", fifo_block, 1);
      pins(4'hF);
      settle();
      check("R7 cleared", {mode, exc}, 0);
    end
    pins(4'b0000);
    settle();
    pins(4'b0011);
    settle();
    check("R7 exc to AB", mode, 1);
    pins(4'hF);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_single();
    t_ab();
    t_ba();
    t_latency();
    t_window();
    t_exc();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule